// File: doc/BRIEF.md
# Multiplexed External Memory Bus Bridge

This block sits between a CPU's data-space port and a narrow external parallel bus. The low address byte and the data byte share one set of lines, and a separate set carries the upper address byte. For each access request the bridge decides whether the address is on chip or off chip. For an off-chip address it runs a bus cycle. That cycle begins with one cycle of address latch enable, during which the low address byte is on the shared lines. It then holds an active-low read or write strobe for a number of cycles that depends on the configured wait states. While the bus cycle runs, the bridge holds the CPU with a stall signal.

Off-chip space can be split into a lower and an upper sector, and each sector has its own wait-state setting. An optional keeper keeps the last driven byte on the shared lines while the bridge is not driving them. The electrical tri-state is represented only by an output-enable signal. When the bridge is enabled, on-chip accesses still show their address and a latch-enable pulse on the bus, but they never pulse a strobe. When the bridge is disabled, it produces no bus activity at all.

Top module: `xbus_bridge`

## Requirements
- R1: With `bus_en`=1, an access with an address from 0x0000 to 0x025F gives one cycle in which `ale`=1, `ad_oe`=1 and `ad_out` is the low address byte. The cycle is the one after the request. Both strobes stay high and `stall` stays low.
- R2: With `bus_en`=1, an access with an address of 0x0260 or above gives, in the cycle after the request, one cycle with `ale`=1, `ad_oe`=1, `ad_out` equal to the low address byte and `addr_hi` equal to the high byte. `ale` then stays low for every strobe cycle of that access.
- R3: An off-chip access with W wait states (W from 0 to 3) raises `stall` for exactly 1+W cycles, starting in the cycle after the request.
- R4: If `sec_limit`=N is nonzero, an off-chip address below N×0x2000 uses `ws_lo`, and an address at or above it uses `ws_hi`.
- R5: If `sec_limit`=0, every off-chip address uses `ws_hi`.
- R6: A read holds `rd_n` low for W+1 cycles, and `ad_oe` is 0 during all of them. `rd_data` takes the value `ad_in` has in the last low cycle and shows it from the next cycle onward.
- R7: A write holds `wr_n` low for W+1 cycles, with `ad_oe`=1 and `ad_out` equal to the write data. `rd_n` and `wr_n` are never low together.
- R8: When `ad_oe`=0, `ad_out` shows the last byte the bridge drove if `keep_en`=1, and 0x00 if `keep_en`=0.
- R9: With `bus_en`=0, no access of any address raises `ale`, a strobe, `ad_oe` or `stall`.
- R10: While `rst` is high, the outputs are `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0, `stall`=0, `rd_data`=0x00 and `ad_out`=0x00.
- R11: A request made in the last strobe cycle of an off-chip access, where `stall` is already low, is accepted. Its address cycle follows in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, taken when `stall` is low |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Data-space address |
| req_wdata | input | 8 | Write byte |
| bus_en | input | 1 | Enables the external bus |
| sec_limit | input | 3 | Sector split point in units of 0x2000; 0 = single sector |
| ws_lo | input | 2 | Wait states for the lower sector |
| ws_hi | input | 2 | Wait states for the upper sector |
| keep_en | input | 1 | Enables the bus keeper on the shared lines |
| ad_in | input | 8 | Byte sensed on the shared lines |
| rd_data | output | 8 | Last byte read from the bus |
| stall | output | 1 | Holds the CPU |
| ad_out | output | 8 | Byte presented on the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| addr_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
Two events can fall in the same cycle: the final strobe cycle of one off-chip access, and the acceptance of the next request. The bench provokes this by issuing every new access in the cycle where its model expects the last strobe record of the previous access. It chains writes, reads and on-chip accesses in this way, with different wait-state counts. It then judges each cycle: the strobe must rise exactly as the new `ale` cycle starts, the read byte must be captured from the old cycle, and the new address must appear without an idle cycle in between.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_INT  = 2'd1,
    XS_ADR  = 2'd2,
    XS_STB  = 2'd3
  } xstate_e;
endpackage

// File: rtl/xbus_decode.sv
module xbus_decode #(
  parameter int AW         = 16,
  parameter int LIMW       = 3,
  parameter int WSW        = 2,
  parameter int INT_TOP    = 'h0260,
  parameter int SECT_SHIFT = 13
) (
  input  logic [AW-1:0]   addr,
  input  logic [LIMW-1:0] limit,
  input  logic [WSW-1:0]  ws_lo,
  input  logic [WSW-1:0]  ws_hi,
  output logic            ext_hit,
  output logic [WSW-1:0]  ws_sel
);
  localparam int BW = AW + LIMW + 1;
  localparam logic [AW-1:0] TOP = AW'(INT_TOP);

  logic [BW-1:0] bound;
  logic          in_lower;

  assign bound    = BW'(limit) << SECT_SHIFT;
  assign in_lower = (limit != '0) && (BW'(addr) < bound);
  assign ext_hit  = (addr >= TOP);
  assign ws_sel   = in_lower ? ws_lo : ws_hi;
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int WSW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic           req_we,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic           bus_en,
  input  logic           ext_hit,
  input  logic [WSW-1:0] ws_sel,
  output xstate_e        st,
  output logic [AW-1:0]  addr_q,
  output logic [DW-1:0]  wdata_q,
  output logic           we_q,
  output logic           last,
  output logic           stall
);
  logic [WSW-1:0] cnt;
  logic           accept;

  assign stall  = (st == XS_ADR) || ((st == XS_STB) && (cnt != '0));
  assign last   = (st == XS_STB) && (cnt == '0);
  assign accept = req_valid && !stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= XS_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
    end else if (accept && bus_en) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      we_q    <= req_we;
      cnt     <= ws_sel;
      st      <= ext_hit ? XS_ADR : XS_INT;
    end else begin
      unique case (st)
        XS_ADR:  st <= XS_STB;
        XS_STB: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else           st  <= XS_IDLE;
        end
        default: st <= XS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xbus_keeper.sv
module xbus_keeper #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          oe,
  input  logic [DW-1:0] drive,
  input  logic          keep_en,
  output logic [DW-1:0] ad_out
);
  logic [DW-1:0] held;

  always_ff @(posedge clk) begin
    if (rst)     held <= '0;
    else if (oe) held <= drive;
  end

  always_comb begin
    if (oe)           ad_out = drive;
    else if (keep_en) ad_out = held;
    else              ad_out = '0;
  end
endmodule

// File: rtl/xbus_bridge.sv
module xbus_bridge
  import xbus_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter int WSW        = 2,
  parameter int LIMW       = 3,
  parameter int INT_TOP    = 'h0260,
  parameter int SECT_SHIFT = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_we,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic             bus_en,
  input  logic [LIMW-1:0]  sec_limit,
  input  logic [WSW-1:0]   ws_lo,
  input  logic [WSW-1:0]   ws_hi,
  input  logic             keep_en,
  input  logic [DW-1:0]    ad_in,
  output logic [DW-1:0]    rd_data,
  output logic             stall,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  output logic [AW-DW-1:0] addr_hi,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n
);
  localparam int HW = AW - DW;

  xstate_e        st;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;
  logic           we_q;
  logic           last;
  logic           ext_hit;
  logic [WSW-1:0] ws_sel;
  logic [DW-1:0]  drv_val;
  logic           strobe;
  logic [DW-1:0]  rd_q;

  xbus_decode #(.AW(AW), .LIMW(LIMW), .WSW(WSW), .INT_TOP(INT_TOP),
                .SECT_SHIFT(SECT_SHIFT)) u_dec (
    .addr(req_addr), .limit(sec_limit), .ws_lo(ws_lo), .ws_hi(ws_hi),
    .ext_hit(ext_hit), .ws_sel(ws_sel)
  );

  xbus_seq #(.AW(AW), .DW(DW), .WSW(WSW)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .bus_en(bus_en),
    .ext_hit(ext_hit), .ws_sel(ws_sel), .st(st), .addr_q(addr_q),
    .wdata_q(wdata_q), .we_q(we_q), .last(last), .stall(stall)
  );

  assign ale     = (st == XS_INT) || (st == XS_ADR);
  assign strobe  = (st == XS_STB);
  assign rd_n    = !(strobe && !we_q);
  assign wr_n    = !(strobe && we_q);
  assign ad_oe   = ale || (strobe && we_q);
  assign drv_val = ale ? addr_q[DW-1:0] : wdata_q;
  assign addr_hi = bus_en ? addr_q[AW-1:DW] : HW'(0);

  xbus_keeper #(.DW(DW)) u_keep (
    .clk(clk), .rst(rst), .oe(ad_oe), .drive(drv_val),
    .keep_en(keep_en), .ad_out(ad_out)
  );

  always_ff @(posedge clk) begin
    if (rst)                rd_q <= '0;
    else if (last && !we_q) rd_q <= ad_in;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/xbus_bridge_chk.sv
module xbus_bridge_chk (
  input logic clk,
  input logic rst,
  input logic bus_en,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic ad_oe,
  input logic stall
);
  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    ale |-> (rd_n && wr_n)); // R1
  AST_STROBE_AFTER_ALE: assert property (@(posedge clk) disable iff (rst)
    ($fell(rd_n) || $fell(wr_n)) |-> $past(ale)); // R2
  AST_STALL_BUS_BUSY: assert property (@(posedge clk) disable iff (rst)
    stall |-> (ale || !rd_n || !wr_n)); // R3
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe); // R6
  AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> ad_oe); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n)); // R7
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!bus_en && !$past(bus_en)) |-> (!ale && rd_n && wr_n && !stall)); // R9
endmodule

bind xbus_bridge xbus_bridge_chk u_chk (
  .clk(clk), .rst(rst), .bus_en(bus_en), .ale(ale), .rd_n(rd_n),
  .wr_n(wr_n), .ad_oe(ad_oe), .stall(stall)
);

// File: tb/xbus_bridge_test.sv
`timescale 1ns/1ps
module xbus_bridge_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic bus_en = 1'b0, keep_en = 1'b0;
  logic [2:0] sec_limit = '0;
  logic [1:0] ws_lo = '0, ws_hi = '0;
  logic [7:0] ad_in = '0;
  logic [7:0] rd_data, ad_out, addr_hi;
  logic stall, ad_oe, ale, rd_n, wr_n;

  always #4 clk = ~clk;

  xbus_bridge uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .bus_en(bus_en),
    .sec_limit(sec_limit), .ws_lo(ws_lo), .ws_hi(ws_hi), .keep_en(keep_en),
    .ad_in(ad_in), .rd_data(rd_data), .stall(stall), .ad_out(ad_out),
    .ad_oe(ad_oe), .addr_hi(addr_hi), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
  );

  typedef struct {
    bit ale; bit rdn; bit wrn; bit oe; bit stl; int ad; int rdv; int hi;
  } rec_t;

  rec_t q[$];
  logic [7:0] ext_mem[int];
  logic [7:0] shadow[int];
  int errors = 0, checks = 0;
  int kept = 0, exp_rd = 0;
  logic [7:0] latch_lo = '0;
  string cur_tag = "R10";
  bit done = 1'b0;

  function automatic logic [7:0] pattern(int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'hA5;
  endfunction

  task automatic chk(string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", cur_tag, what, got, exp);
    end
  endtask

  task automatic push_access(bit we, int addr, int data);
    int w;
    rec_t r;
    if (!bus_en) return;
    if (addr < 'h260) begin
      r = '{ale:1, rdn:1, wrn:1, oe:1, stl:0, ad:addr & 255, rdv:-1, hi:addr >> 8};
      q.push_back(r);
      return;
    end
    if (sec_limit != 0 && addr < sec_limit * 'h2000) w = ws_lo;
    else w = ws_hi;
    r = '{ale:1, rdn:1, wrn:1, oe:1, stl:1, ad:addr & 255, rdv:-1, hi:addr >> 8};
    q.push_back(r);
    for (int k = 0; k <= w; k++) begin
      r.ale = 0; r.rdn = we; r.wrn = !we; r.oe = we; r.stl = (k < w);
      r.ad  = we ? data : -1;
      r.rdv = -1;
      if (!we && k == w) r.rdv = shadow.exists(addr) ? shadow[addr] : pattern(addr);
      q.push_back(r);
    end
    if (we) shadow[addr] = 8'(data);
  endtask

  task automatic step(bit do_req, bit we, int addr, int data);
    rec_t r;
    int bus_a;
    @(negedge clk);
    if (q.size() > 0) r = q.pop_front();
    else r = '{ale:0, rdn:1, wrn:1, oe:0, stl:0, ad:-1, rdv:-1, hi:-1};
    chk("ale", ale, r.ale);
    chk("rd_n", rd_n, r.rdn);
    chk("wr_n", wr_n, r.wrn);
    chk("ad_oe", ad_oe, r.oe);
    chk("stall", stall, r.stl);
    chk("rd_data", rd_data, exp_rd);
    if (r.ad >= 0) chk("ad_out", ad_out, r.ad);
    else           chk("ad_out kept", ad_out, keep_en ? kept : 0);
    if (r.hi >= 0) chk("addr_hi", addr_hi, r.hi);
    if (r.oe) kept = r.ad;
    if (r.rdv >= 0) exp_rd = r.rdv;
    if (ale) latch_lo = ad_out;
    bus_a = {addr_hi, latch_lo};
    if (!wr_n) ext_mem[bus_a] = ad_out;
    if (!rd_n) ad_in = ext_mem.exists(bus_a) ? ext_mem[bus_a] : pattern(bus_a);
    else       ad_in = 8'h00;
    req_valid = do_req; req_we = we;
    req_addr = 16'(addr); req_wdata = 8'(data);
    if (do_req) push_access(we, addr, data);
  endtask

  task automatic access(bit we, int addr, int data);
    while (q.size() > 1) step(0, 0, 0, 0);
    step(1, we, addr, data);
  endtask

  task automatic drain();
    while (q.size() > 0) step(0, 0, 0, 0);
    step(0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_tag = "R10";
    chk("ale", ale, 0); chk("rd_n", rd_n, 1); chk("wr_n", wr_n, 1);
    chk("ad_oe", ad_oe, 0); chk("stall", stall, 0);
    chk("rd_data", rd_data, 0); chk("ad_out", ad_out, 0);
    rst = 1'b0;
    bus_en = 1; keep_en = 1; sec_limit = 0; ws_lo = 0; ws_hi = 0;
    step(0, 0, 0, 0);

    cur_tag = "R1";
    access(0, 'h0010, 0); access(1, 'h025F, 'h11); access(0, 'h0100, 0);
    drain();

    cur_tag = "R2";
    access(1, 'h0260, 'h3C); drain();
    cur_tag = "R7";
    access(1, 'h1234, 'hC3); drain();
    cur_tag = "R6";
    access(0, 'h0260, 0); drain();
    access(0, 'h7788, 0); drain();

    cur_tag = "R5";
    ws_lo = 1; ws_hi = 3; step(0, 0, 0, 0);
    access(1, 'h1000, 'h5A); drain();
    access(0, 'h1000, 0); drain();
    access(0, 'h8000, 0); drain();

    cur_tag = "R4";
    sec_limit = 2; step(0, 0, 0, 0);
    access(0, 'h3FFF, 0); drain();
    access(1, 'h4000, 'h77); drain();
    ws_lo = 2; ws_hi = 0; sec_limit = 7; step(0, 0, 0, 0);
    access(1, 'hDFFF, 'h99); drain();
    access(0, 'hE000, 0); drain();
    access(0, 'hDFFF, 0); drain();

    cur_tag = "R3";
    for (int w = 0; w < 4; w++) begin
      sec_limit = 0; ws_hi = 2'(w); step(0, 0, 0, 0);
      access(0, 'h0400 + w, 0); drain();
    end

    cur_tag = "R8";
    keep_en = 0; step(0, 0, 0, 0);
    access(0, 'h2222, 0); drain();
    keep_en = 1; step(0, 0, 0, 0);
    access(0, 'h2223, 0); drain();

    cur_tag = "R11";
    ws_hi = 1; step(0, 0, 0, 0);
    access(1, 'h5000, 'hE1); access(0, 'h5000, 0); access(0, 'h0020, 0);
    access(1, 'h6001, 'h0F); access(0, 'h6001, 0);
    drain();

    cur_tag = "R9";
    bus_en = 0; step(0, 0, 0, 0); step(0, 0, 0, 0);
    access(0, 'h9000, 0); access(1, 'h0010, 'h55); access(1, 'hFFFF, 'hAA);
    drain(); drain();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule